// File: doc/BRIEF.md
# VID Slew-Rate Sequencer with Power-Good

This block steps a 6-bit output-voltage DAC code toward a target value, one code (one 12.5 mV LSB) at a time, paced by a slew tick pulse. Its target is the 6-bit VID input word in normal mode. In suspend mode it is a 2-bit suspend selection translated through a small lookup. The block sequences a complete power cycle. After shutdown is released it enables the reference and waits for it to be ready. It then ramps up from zero at a quarter of the normal pace and tracks VID changes at full pace. On shutdown it ramps back down to zero at the slow pace and parks.

A power-good output rises only after the code has held at its target for a programmable number of millisecond ticks. It drops at once on shutdown or fault. Any of three fault inputs (undervoltage, overvoltage, thermal) starts the same ramp-down and sets a latch that blocks restart. Only a low-then-high toggle of the shutdown input, or reset, clears that latch. Once parked at zero, the block holds the low-side enable high, the high-side enable low and the reference enable low.

Top module: `vid_slew_seq`

## Requirements
- R1: The DAC code never changes by more than one code between consecutive clock cycles, and each change moves it toward the current goal.
- R2: With `susp_sel` = 0 the target is `vid`. With `susp_sel` = 1 the target comes from `susp_code` through the lookup 0→8, 1→16, 2→24, 3→32.
- R3: From OFF or PARKED, `shdn_n` high with no latched fault moves the block to WAIT_REF and raises `ref_en`. The block stays in WAIT_REF with the code at 0 until `ref_ready` is high.
- R4: In SOFT_RAMP the code advances by one on every fourth slew tick counted from entry into the state. One cycle after the code equals the target, the state becomes REGULATE.
- R5: In REGULATE the code follows target changes by one step per slew tick, upward or downward.
- R6: `pgood` rises one cycle after the third (HOLD_TICKS) ms tick counted while in REGULATE with the code at the target. A target change while `pgood` is low restarts that count. Once high, `pgood` does not drop when the target changes.
- R7: One cycle after `shdn_n` goes low, `pgood` is 0 and the state is SHDN_RAMP. The code then falls by one on every fourth slew tick.
- R8: One cycle after the code reaches 0 in SHDN_RAMP, the state is PARKED, with `lo_en` = 1, `hi_en` = 0 and `ref_en` = 0.
- R9: A high on `flt_uv`, `flt_ov` or `flt_ot` in WAIT_REF, SOFT_RAMP or REGULATE drops `pgood` and enters SHDN_RAMP on the next cycle. It also latches a fault that keeps the block in PARKED while `shdn_n` stays high.
- R10: Driving `shdn_n` low for at least one cycle clears the fault latch. Raising it again then moves PARKED to WAIT_REF on the next cycle.
- R11: After reset, the state is OFF, the code is 0, `pgood` = 0, `lo_en` = 1, `hi_en` = 0 and `ref_en` = 0. `state_o` encodes OFF=0, WAIT_REF=1, SOFT_RAMP=2, REGULATE=3, SHDN_RAMP=4, PARKED=5. In SOFT_RAMP, REGULATE and SHDN_RAMP, `hi_en` = 1 and `lo_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shdn_n | input | 1 | High to run, low to shut down |
| susp_sel | input | 1 | 1 selects the suspend target |
| vid | input | 6 | Normal-mode target code |
| susp_code | input | 2 | Suspend target selection |
| ref_ready | input | 1 | Reference has passed its lockout |
| slew_tick | input | 1 | One-cycle slew pacing pulse |
| ms_tick | input | 1 | One-cycle 1 kHz timer pulse |
| flt_uv | input | 1 | Undervoltage fault |
| flt_ov | input | 1 | Overvoltage fault |
| flt_ot | input | 1 | Thermal fault |
| dac_code | output | 6 | Present DAC code |
| pgood | output | 1 | Power-good |
| lo_en | output | 1 | Low-side drive enable |
| hi_en | output | 1 | High-side drive enable |
| ref_en | output | 1 | Reference enable |
| state_o | output | 3 | Sequencer state |

## Verification
A wrong sequencer state is visible on `state_o` and on the drive enables one cycle after the edge that caused it. A wrong divider phase shows up as a code step one slew tick early or late during either slow ramp. A miscounted or unrestarted hold-off moves the `pgood` rising edge by at least one ms tick. A lost or stuck fault latch shows as a restart from PARKED when none is allowed, or as no restart after a shutdown toggle, in the cycle after `shdn_n` rises.

// File: rtl/vss_pkg.sv
// Package: shared state and motion encodings for the VID slew sequencer.
// Assumes: state values are visible on the status port and must stay fixed.
package vss_pkg;
    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_WAIT_REF  = 3'd1,
        ST_SOFT_RAMP = 3'd2,
        ST_REGULATE  = 3'd3,
        ST_SHDN_RAMP = 3'd4,
        ST_PARKED    = 3'd5
    } vss_state_e;

    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_SLOW = 2'd1,
        MV_FAST = 2'd2
    } vss_move_e;
endpackage

// File: rtl/vss_target_sel.sv
// Target selector: picks the VID word or a suspend code from a computed lookup.
// Assumes: lookup entries are SUSP_BASE + index*SUSP_STEP and fit in CODE_W bits.
module vss_target_sel #(
    parameter int CODE_W    = 6,
    parameter int SUSP_W    = 2,
    parameter int SUSP_BASE = 8,
    parameter int SUSP_STEP = 8
) (
    input  logic              susp_sel,
    input  logic [CODE_W-1:0] vid,
    input  logic [SUSP_W-1:0] susp_code,
    output logic [CODE_W-1:0] target
);
    localparam int NSUSP = 1 << SUSP_W;

    logic [CODE_W-1:0] lut [NSUSP];

    // Build one lookup entry per suspend selection.
    for (genvar i = 0; i < NSUSP; i++) begin : g_lut
        assign lut[i] = CODE_W'(SUSP_BASE + i * SUSP_STEP);
    end

    // Choose the active target source.
    always_comb begin
        target = susp_sel ? lut[susp_code] : vid;
    end
endmodule

// File: rtl/vss_stepper.sv
// Code stepper: moves the DAC code one LSB toward a goal on paced ticks.
// Assumes: in slow mode a step is taken on every DIV-th tick after div_clr.
module vss_stepper
    import vss_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int DIV    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  vss_move_e         mode,
    input  logic              div_clr,
    input  logic              tick,
    input  logic [CODE_W-1:0] goal,
    output logic [CODE_W-1:0] code
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_cnt;
    logic          step_ok;

    // Decide whether this cycle's tick produces a step.
    always_comb begin
        step_ok = 1'b0;
        if (tick) begin
            if (mode == MV_FAST)
                step_ok = 1'b1;
            else if (mode == MV_SLOW)
                step_ok = (div_cnt == DW'(DIV - 1));
        end
    end

    // Count slow-mode ticks between steps.
    always_ff @(posedge clk) begin
        if (!rst_n || div_clr)
            div_cnt <= '0;
        else if (tick && mode == MV_SLOW)
            div_cnt <= step_ok ? '0 : div_cnt + DW'(1);
    end

    // Move the code by one toward the goal.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code <= '0;
        else if (step_ok && code < goal)
            code <= code + CODE_W'(1);
        else if (step_ok && code > goal)
            code <= code - CODE_W'(1);
    end
endmodule

// File: rtl/vss_pgood_timer.sv
// Power-good timer: raises pgood after HOLD_TICKS ms ticks spent at target.
// Assumes: run is low whenever the sequencer is not regulating.
module vss_pgood_timer #(
    parameter int CODE_W     = 6,
    parameter int HOLD_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              at_target,
    input  logic [CODE_W-1:0] target,
    input  logic              ms_tick,
    output logic              pgood
);
    localparam int CW = $clog2(HOLD_TICKS + 1);

    logic [CW-1:0]     cnt;
    logic [CODE_W-1:0] tgt_prev;
    logic              tgt_chg;

    // Remember the last target to spot changes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tgt_prev <= '0;
        else
            tgt_prev <= target;
    end

    // Flag a target change this cycle.
    always_comb begin
        tgt_chg = (target != tgt_prev);
    end

    // Count the hold-off and latch power-good while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            pgood <= 1'b0;
        end else if (!pgood) begin
            if (!at_target || tgt_chg)
                cnt <= '0;
            else if (ms_tick) begin
                if (cnt == CW'(HOLD_TICKS - 1))
                    pgood <= 1'b1;
                else
                    cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/vid_slew_seq.sv
// VID slew sequencer top: power-up, tracking, shutdown and fault sequencing.
// Assumes: slew_tick and ms_tick are one-cycle pulses synchronous to clk.
module vid_slew_seq
    import vss_pkg::*;
#(
    parameter int CODE_W     = 6,
    parameter int SUSP_W     = 2,
    parameter int SUSP_BASE  = 8,
    parameter int SUSP_STEP  = 8,
    parameter int SLOW_DIV   = 4,
    parameter int HOLD_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shdn_n,
    input  logic              susp_sel,
    input  logic [CODE_W-1:0] vid,
    input  logic [SUSP_W-1:0] susp_code,
    input  logic              ref_ready,
    input  logic              slew_tick,
    input  logic              ms_tick,
    input  logic              flt_uv,
    input  logic              flt_ov,
    input  logic              flt_ot,
    output logic [CODE_W-1:0] dac_code,
    output logic              pgood,
    output logic              lo_en,
    output logic              hi_en,
    output logic              ref_en,
    output logic [2:0]        state_o
);
    vss_state_e        st_q, st_d;
    vss_move_e         mode;
    logic [CODE_W-1:0] target, goal;
    logic              fault_any, stop, active, flt_lat, run;

    vss_target_sel #(
        .CODE_W(CODE_W), .SUSP_W(SUSP_W),
        .SUSP_BASE(SUSP_BASE), .SUSP_STEP(SUSP_STEP)
    ) u_tsel (
        .susp_sel(susp_sel), .vid(vid), .susp_code(susp_code), .target(target)
    );

    vss_stepper #(.CODE_W(CODE_W), .DIV(SLOW_DIV)) u_step (
        .clk(clk), .rst_n(rst_n), .mode(mode), .div_clr(st_d != st_q),
        .tick(slew_tick), .goal(goal), .code(dac_code)
    );

    vss_pgood_timer #(.CODE_W(CODE_W), .HOLD_TICKS(HOLD_TICKS)) u_pg (
        .clk(clk), .rst_n(rst_n), .run(run), .at_target(dac_code == target),
        .target(target), .ms_tick(ms_tick), .pgood(pgood)
    );

    // Combine fault sources and the shutdown request.
    always_comb begin
        fault_any = flt_uv | flt_ov | flt_ot;
        stop      = !shdn_n || fault_any;
        active    = (st_q == ST_WAIT_REF) || (st_q == ST_SOFT_RAMP) || (st_q == ST_REGULATE);
        run       = (st_q == ST_REGULATE) && !stop;
    end

    // Next-state logic of the sequencer.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_OFF, ST_PARKED: if (shdn_n && !flt_lat) st_d = ST_WAIT_REF;
            ST_WAIT_REF:       if (stop) st_d = ST_SHDN_RAMP;
                               else if (ref_ready) st_d = ST_SOFT_RAMP;
            ST_SOFT_RAMP:      if (stop) st_d = ST_SHDN_RAMP;
                               else if (dac_code == target) st_d = ST_REGULATE;
            ST_REGULATE:       if (stop) st_d = ST_SHDN_RAMP;
            ST_SHDN_RAMP:      if (dac_code == '0) st_d = ST_PARKED;
            default:           st_d = ST_OFF;
        endcase
    end

    // Pick step pacing and goal for the current state.
    always_comb begin
        mode = MV_HOLD;
        goal = '0;
        case (st_q)
            ST_SOFT_RAMP: begin mode = MV_SLOW; goal = target; end
            ST_REGULATE:  begin mode = MV_FAST; goal = target; end
            ST_SHDN_RAMP: begin mode = MV_SLOW; goal = '0;     end
            default:      begin mode = MV_HOLD; goal = '0;     end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_OFF;
        else
            st_q <= st_d;
    end

    // Fault latch: set by a fault while running, cleared while shut down.
    always_ff @(posedge clk) begin
        if (!rst_n || !shdn_n)
            flt_lat <= 1'b0;
        else if (fault_any && active)
            flt_lat <= 1'b1;
    end

    // Drive enables and status from the state.
    always_comb begin
        hi_en   = (st_q == ST_SOFT_RAMP) || (st_q == ST_REGULATE) || (st_q == ST_SHDN_RAMP);
        lo_en   = !hi_en;
        ref_en  = (st_q != ST_OFF) && (st_q != ST_PARKED);
        state_o = st_q;
    end
endmodule

// File: rtl/vss_checker.sv
// Checker: temporal properties of the VID slew sequencer, seen at its ports.
// Assumes: bound to vid_slew_seq with its default state encoding.
module vss_checker #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shdn_n,
    input logic              ref_ready,
    input logic              slew_tick,
    input logic              ms_tick,
    input logic              flt_uv,
    input logic              flt_ov,
    input logic              flt_ot,
    input logic [CODE_W-1:0] dac_code,
    input logic              pgood,
    input logic              lo_en,
    input logic              hi_en,
    input logic              ref_en,
    input logic [2:0]        state_o
);
    // R1: code moves at most one LSB per cycle.
    a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code != $past(dac_code)) |->
        (dac_code == $past(dac_code) + CODE_W'(1) || dac_code == $past(dac_code) - CODE_W'(1)));

    // R3: no ready reference keeps the block waiting.
    a_r3_wait_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && !ref_ready && shdn_n && !flt_uv && !flt_ov && !flt_ot) |=> (state_o == 3'd1));

    // R4: soft-ramp steps only follow a slew tick.
    a_r4_soft_paced: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && $past(state_o) == 3'd2 && dac_code != $past(dac_code)) |-> $past(slew_tick));

    // R5: tracking steps only follow a slew tick.
    a_r5_track_paced: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && $past(state_o) == 3'd3 && dac_code != $past(dac_code)) |-> $past(slew_tick));

    // R6: power-good rises only on a ms tick.
    a_r6_pgood_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood) |-> $past(ms_tick));

    // R7: shutdown drops power-good on the next cycle.
    a_r7_shdn_drops_pg: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> !pgood);

    // R8: parked outputs.
    a_r8_parked_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd5) |-> (lo_en && !hi_en && !ref_en && dac_code == '0));

    // R9: a fault drops power-good on the next cycle.
    a_r9_fault_drops_pg: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_uv || flt_ov || flt_ot) |=> !pgood);
endmodule

bind vid_slew_seq vss_checker #(.CODE_W(CODE_W)) u_vss_chk (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .ref_ready(ref_ready),
    .slew_tick(slew_tick), .ms_tick(ms_tick), .flt_uv(flt_uv), .flt_ov(flt_ov),
    .flt_ot(flt_ot), .dac_code(dac_code), .pgood(pgood), .lo_en(lo_en),
    .hi_en(hi_en), .ref_en(ref_en), .state_o(state_o)
);

// File: tb/vid_slew_seq_bench.sv
// Bench: directed scenarios for the VID slew sequencer, one task each.
module vid_slew_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shdn_n = 1'b0, susp_sel = 1'b0, ref_ready = 1'b0;
    logic [5:0] vid = '0;
    logic [1:0] susp_code = '0;
    logic       slew_tick = 1'b0, ms_tick = 1'b0;
    logic       flt_uv = 1'b0, flt_ov = 1'b0, flt_ot = 1'b0;
    logic [5:0] dac_code;
    logic       pgood, lo_en, hi_en, ref_en;
    logic [2:0] state_o;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    vid_slew_seq u_vid_slew_seq (
        .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .susp_sel(susp_sel), .vid(vid),
        .susp_code(susp_code), .ref_ready(ref_ready), .slew_tick(slew_tick),
        .ms_tick(ms_tick), .flt_uv(flt_uv), .flt_ov(flt_ov), .flt_ot(flt_ot),
        .dac_code(dac_code), .pgood(pgood), .lo_en(lo_en), .hi_en(hi_en),
        .ref_en(ref_en), .state_o(state_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic slew(input int n);
        for (int i = 0; i < n; i++) begin
            slew_tick = 1'b1; @(negedge clk);
            slew_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic mstick(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1; @(negedge clk);
            ms_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 state", state_o, 0);
        check("R11 code", dac_code, 0);
        check("R11 pgood", pgood, 0);
        check("R11 lo_en", lo_en, 1);
        check("R11 hi_en", hi_en, 0);
        check("R11 ref_en", ref_en, 0);
    endtask

    task automatic t_startup;
        vid = 6'd5; shdn_n = 1'b1;
        @(negedge clk);
        check("R3 wait state", state_o, 1);
        check("R3 ref_en", ref_en, 1);
        repeat (3) @(negedge clk);
        check("R3 held waiting", state_o, 1);
        check("R3 code zero", dac_code, 0);
        ref_ready = 1'b1;
        @(negedge clk);
        check("R4 soft state", state_o, 2);
        check("R11 hi_en ramp", hi_en, 1);
        slew(3);
        check("R4 no step before 4th tick", dac_code, 0);
        slew(1);
        check("R4 step on 4th tick", dac_code, 1);
        slew(15);
        check("R4 code before last", dac_code, 4);
        check("R4 still soft", state_o, 2);
        slew(1);
        check("R4 code at target", dac_code, 5);
        check("R4 regulate", state_o, 3);
        check("R11 lo_en regulate", lo_en, 0);
    endtask

    task automatic t_pgood;
        mstick(2);
        check("R6 pgood early", pgood, 0);
        vid = 6'd6;
        slew(1);
        check("R5 track up", dac_code, 6);
        mstick(2);
        check("R6 count restarted", pgood, 0);
        mstick(1);
        check("R6 pgood high", pgood, 1);
    endtask

    task automatic t_track;
        vid = 6'd4;
        slew(1);
        check("R5 track down 1", dac_code, 5);
        check("R6 pgood kept", pgood, 1);
        slew(1);
        check("R5 track down 2", dac_code, 4);
        susp_sel = 1'b1; susp_code = 2'd0;
        slew(1);
        check("R1 single step", dac_code, 5);
        slew(3);
        check("R2 suspend 0 -> 8", dac_code, 8);
        susp_code = 2'd3;
        slew(24);
        check("R2 suspend 3 -> 32", dac_code, 32);
        susp_code = 2'd0;
        slew(24);
        check("R2 back to 8", dac_code, 8);
    endtask

    task automatic t_shutdown;
        shdn_n = 1'b0;
        @(negedge clk);
        check("R7 pgood drop", pgood, 0);
        check("R7 shdn state", state_o, 4);
        slew(3);
        check("R7 no early step", dac_code, 8);
        slew(1);
        check("R7 step down", dac_code, 7);
        slew(28);
        check("R8 code zero", dac_code, 0);
        check("R8 parked", state_o, 5);
        check("R8 lo_en", lo_en, 1);
        check("R8 hi_en", hi_en, 0);
        check("R8 ref_en", ref_en, 0);
    endtask

    task automatic t_fault;
        susp_sel = 1'b0; vid = 6'd2;
        shdn_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 restart soft", state_o, 2);
        slew(8);
        check("R9 pre-fault regulate", state_o, 3);
        flt_ov = 1'b1; @(negedge clk); flt_ov = 1'b0;
        check("R9 ov shdn ramp", state_o, 4);
        check("R9 pgood low", pgood, 0);
        slew(8);
        check("R9 parked", state_o, 5);
        repeat (4) @(negedge clk);
        check("R9 latch blocks", state_o, 5);
        check("R9 ref off", ref_en, 0);
        shdn_n = 1'b0; @(negedge clk);
        ref_ready = 1'b0; shdn_n = 1'b1; @(negedge clk);
        check("R10 toggle restarts", state_o, 1);
        flt_uv = 1'b1; @(negedge clk); flt_uv = 1'b0;
        check("R9 uv in wait", state_o, 4);
        @(negedge clk);
        repeat (3) @(negedge clk);
        check("R9 uv latch blocks", state_o, 5);
        shdn_n = 1'b0; @(negedge clk);
        shdn_n = 1'b1; @(negedge clk);
        check("R10 second toggle", state_o, 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_startup();
        t_pgood();
        t_track();
        t_shutdown();
        t_fault();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule